// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

A memory-mapped event timer built around a single free-running main counter and a configurable number of comparator channels. Software programs each channel with a comparator value; when the main counter reaches that value the channel fires. Each channel can fire once (one-shot) or keep firing at a fixed interval (periodic, on channels built with that capability). It can signal a firing either as a latched level that software acknowledges or as a single-cycle pulse. Each channel can also be restricted to the low 32 bits of the count.

The block sits on a simple word-addressed register bus with an address, write data, a write strobe and combinational read data. It drives one interrupt line per channel. Each channel is controlled by a small state machine with three states. `CH_IDLE` means disarmed or already fired. `CH_ARMED` means it is waiting for a match. `CH_WAIT_PERIOD` means the first match time of a periodic channel has been written and the period is still to come. The transitions are as follows:
- idle-to-armed: a comparator write.
- armed-to-idle: a one-shot match.
- armed-to-armed: a periodic match, which advances the comparator.
- idle/armed-to-wait-period: a comparator write while the channel is periodic with the value-set bit on.
- wait-period-to-armed: the next comparator write.

Word addresses: 0 capability, 1 global control, 2 status, 3 main counter; channel i has its configuration at 4+2i and its comparator at 5+2i.

Top module: `evt_timer`

## Requirements
- R1: After reset the capability word reads {TICK_FS in bits 63:32, bit 8 = 1 for a 64-bit counter, channel count minus one in bits 7:0}; global control, main counter, status and all interrupts read 0.
- R2: While the run bit (global control bit 0) is 1 the main counter advances by one per clock; while it is 0 the counter holds.
- R3: A write to the main counter takes effect only while the run bit is 0; while running it is ignored and counting continues.
- R4: Status bit i belongs to channel i; writing 1 to a status bit clears it, writing 0 leaves it unchanged.
- R5: A channel in level mode (config bit 0 = 1) sets its status bit on a match and keeps it until cleared. Its interrupt equals status AND enable. A match and a clearing write in the same cycle leave the bit set.
- R6: With the interrupt-enable bit (config bit 1) at 0, a match raises no interrupt.
- R7: A one-shot channel (config bit 2 = 0) matches when the counter equals the comparator, and fires only once until the comparator is written again.
- R8: On a periodic channel (config bit 2 = 1) with value-set (config bit 4) at 1, the first comparator write sets the first match time and clears value-set; the next comparator write sets the period.
- R9: On each periodic match the comparator advances by the stored period, so matches repeat without software action.
- R10: Config bit 3 reads 1 only on periodic-capable channels; on other channels writes to the periodic bit are ignored.
- R11: In 32-bit mode (config bit 5 = 1) comparator writes keep only the low 32 bits, and matching uses only the low 32 bits of the counter.
- R12: In edge mode (config bit 0 = 0) each match drives the interrupt high for exactly the one cycle after the counter held the comparator value, and the status bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i |
| irq_o | output | NUM_CH | Per-channel interrupt |

## Verification
Two things can land on a level-mode status bit in the same clock: a comparator match that sets it, and a software write-one that clears it. The bench halts the counter, loads it so that the match falls exactly on the edge where a status clear commits, and then expects the bit and the interrupt to be still high. A second clear must then drop both. The checker also requires that a set status bit survives every cycle without a clearing write.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CAP  = 5'd0;
    localparam logic [ADDR_W-1:0] A_GCFG = 5'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 5'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'd3;
    localparam int CH_BASE = 4;

    localparam int CB_LEVEL    = 0;
    localparam int CB_IEN      = 1;
    localparam int CB_PERIODIC = 2;
    localparam int CB_PERCAP   = 3;
    localparam int CB_VALSET   = 4;
    localparam int CB_MODE32   = 5;

    typedef enum logic [1:0] {
        CH_IDLE        = 2'd0,
        CH_ARMED       = 2'd1,
        CH_WAIT_PERIOD = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic mode32;
        logic valset;
        logic periodic;
        logic ien;
        logic level;
    } ch_cfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_o <= '0;
        else if (run_i)  cnt_o <= cnt_o + CNT_W'(1);
        else if (load_i) cnt_o <= load_val_i;
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter bit PER_CAP = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic              cmp_we_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              fire_o,
    output logic              pulse_o,
    output logic              level_o,
    output logic              ien_o,
    output logic [DATA_W-1:0] rd_cfg_o,
    output logic [DATA_W-1:0] rd_cmp_o
);
    localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'({32{1'b1}});

    ch_state_e        st_q, st_d;
    ch_cfg_t          cfg_q;
    logic [CNT_W-1:0] cmp_q, per_q, eff_mask, wval;
    logic             hit, two_step;

    assign eff_mask = cfg_q.mode32 ? LOW_MASK : '1;
    assign wval     = wdata_i & eff_mask;
    assign two_step = cfg_q.periodic && cfg_q.valset;
    assign hit      = run_i && (((cnt_i ^ cmp_q) & eff_mask) == '0);
    assign fire_o   = (st_q == CH_ARMED) && hit && !cmp_we_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= CH_IDLE;
        else         st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (cmp_we_i) st_d = two_step ? CH_WAIT_PERIOD : CH_ARMED;
            end
            CH_ARMED: begin
                if (cmp_we_i)                      st_d = two_step ? CH_WAIT_PERIOD : CH_ARMED;
                else if (fire_o && !cfg_q.periodic) st_d = CH_IDLE;
            end
            CH_WAIT_PERIOD: begin
                if (cmp_we_i) st_d = CH_ARMED;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q   <= '0;
            cmp_q   <= '0;
            per_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire_o && !cfg_q.level;
            if (cfg_we_i) begin
                cfg_q.level    <= wdata_i[CB_LEVEL];
                cfg_q.ien      <= wdata_i[CB_IEN];
                cfg_q.periodic <= PER_CAP && wdata_i[CB_PERIODIC];
                cfg_q.valset   <= wdata_i[CB_VALSET];
                cfg_q.mode32   <= wdata_i[CB_MODE32];
            end
            if (cmp_we_i) begin
                if (st_q == CH_WAIT_PERIOD) begin
                    per_q <= wval;
                end else begin
                    cmp_q <= wval;
                    if (two_step) cfg_q.valset <= 1'b0;
                    else          per_q <= wval;
                end
            end else if (fire_o && cfg_q.periodic) begin
                cmp_q <= (cmp_q + per_q) & eff_mask;
            end
        end
    end

    assign level_o  = cfg_q.level;
    assign ien_o    = cfg_q.ien;
    assign rd_cfg_o = DATA_W'({cfg_q.mode32, cfg_q.valset, PER_CAP,
                               cfg_q.periodic, cfg_q.ien, cfg_q.level});
    assign rd_cmp_o = DATA_W'(cmp_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int                NUM_CH       = 3,
    parameter bit                WIDE_CNT     = 1'b1,
    parameter logic [31:0]       TICK_FS      = 32'd10_000_000,
    parameter logic [NUM_CH-1:0] PER_CAP_MASK = 'b011
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int CNT_W = WIDE_CNT ? 64 : 32;

    logic                run_q;
    logic [CNT_W-1:0]    cnt;
    logic [NUM_CH-1:0]   status_q, ch_fire, ch_pulse, ch_level, ch_ien;
    logic [DATA_W-1:0]   rd_cfg [NUM_CH];
    logic [DATA_W-1:0]   rd_cmp [NUM_CH];
    logic                stat_we;

    assign stat_we = we_i && (addr_i == A_STAT);

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        run_q <= 1'b0;
        else if (we_i && addr_i == A_GCFG)  run_q <= wdata_i[0];
    end

    evt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_q),
        .load_i     (we_i && (addr_i == A_CNT) && !run_q),
        .load_val_i (wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evt_channel #(.CNT_W(CNT_W), .PER_CAP(PER_CAP_MASK[i])) u_ch (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .cfg_we_i (we_i && (addr_i == ADDR_W'(CH_BASE + 2*i))),
            .cmp_we_i (we_i && (addr_i == ADDR_W'(CH_BASE + 2*i + 1))),
            .wdata_i  (wdata_i[CNT_W-1:0]),
            .run_i    (run_q),
            .cnt_i    (cnt),
            .fire_o   (ch_fire[i]),
            .pulse_o  (ch_pulse[i]),
            .level_o  (ch_level[i]),
            .ien_o    (ch_ien[i]),
            .rd_cfg_o (rd_cfg[i]),
            .rd_cmp_o (rd_cmp[i])
        );
        assign irq_o[i] = ch_ien[i] && (ch_level[i] ? status_q[i] : ch_pulse[i]);
    end

    // status: a level-mode match wins over a same-cycle clear
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_fire[i] && ch_level[i])     status_q[i] <= 1'b1;
                else if (stat_we && wdata_i[i])    status_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CAP:   rdata_o = {TICK_FS, 23'd0, WIDE_CNT, 8'(NUM_CH - 1)};
            A_GCFG:  rdata_o = DATA_W'(run_q);
            A_STAT:  rdata_o = DATA_W'(status_q);
            A_CNT:   rdata_o = DATA_W'(cnt);
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (addr_i == ADDR_W'(CH_BASE + 2*i))     rdata_o = rd_cfg[i];
                    if (addr_i == ADDR_W'(CH_BASE + 2*i + 1)) rdata_o = rd_cmp[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              we_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [NUM_CH-1:0] irq_o,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] status_q,
    input logic [NUM_CH-1:0] ch_level,
    input logic [NUM_CH-1:0] ch_ien
);
    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q |=> cnt == $past(cnt) + CNT_W'(1));

    p_count_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_q && !(we_i && addr_i == A_CNT)) |=> $stable(cnt));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[i] |-> ch_ien[i]);

        p_status_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_q[i] && !(we_i && addr_i == A_STAT && wdata_i[i])) |=> status_q[i]);

        p_status_level_only_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(status_q[i]) |-> $past(ch_level[i]));
    end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .run_q    (run_q),
    .cnt      (cnt),
    .status_q (status_q),
    .ch_level (ch_level),
    .ch_ien   (ch_ien)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [4:0]  addr_i = '0;
    logic        we_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic [63:0] rdata_o;
    logic [2:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk_i = ~clk_i;

    evt_timer u_evt_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [63:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd0, 64'h0098_9680_0000_0102, 8'd1},  // R1 capability
        '{1'b1, 5'd1, 64'h0, 8'd1},                    // R1 control
        '{1'b1, 5'd3, 64'h0, 8'd1},                    // R1 counter
        '{1'b1, 5'd2, 64'h0, 8'd1},                    // R1 status
        '{1'b0, 5'd3, 64'd100, 8'd3},                  // R3 load while halted
        '{1'b1, 5'd3, 64'd100, 8'd3},
        '{1'b0, 5'd8, 64'h4, 8'd10},                   // R10 ch2 not capable
        '{1'b1, 5'd8, 64'h0, 8'd10},
        '{1'b0, 5'd4, 64'h4, 8'd10},                   // R10 ch0 capable
        '{1'b1, 5'd4, 64'hC, 8'd10},
        '{1'b0, 5'd6, 64'h20, 8'd11},                  // R11 truncation
        '{1'b0, 5'd7, 64'h1234_5678_9ABC_DEF0, 8'd11},
        '{1'b1, 5'd7, 64'h9ABC_DEF0, 8'd11},
        '{1'b0, 5'd4, 64'h0, 8'd10},
        '{1'b0, 5'd6, 64'h0, 8'd11},
        '{1'b1, 5'd4, 64'h8, 8'd10}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk_i);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] v, w;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 irq after reset", 64'(irq_o), 64'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].rd) begin
                rd(VECS[k].addr, v);
                check($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].data);
            end else begin
                wr(VECS[k].addr, VECS[k].data);
            end
        end

        // R5 / R7 level one-shot on channel 0
        wr(5'd3, 64'd0);
        wr(5'd4, 64'h3);
        wr(5'd5, 64'd10);
        wr(5'd1, 64'd1);
        repeat (10) @(negedge clk_i);
        rd(5'd3, v);
        check("R2 counter advances", v, 64'd10);
        check("R7 no irq before match", 64'(irq_o[0]), 64'd0);
        @(negedge clk_i);
        check("R5 level irq on match", 64'(irq_o[0]), 64'd1);
        rd(5'd2, v);
        check("R5 status set", v, 64'h1);
        repeat (5) @(negedge clk_i);
        check("R5 level held", 64'(irq_o[0]), 64'd1);
        wr(5'd2, 64'h0);
        rd(5'd2, v);
        check("R4 write zero keeps", v, 64'h1);
        wr(5'd2, 64'h1);
        rd(5'd2, v);
        check("R4 write one clears", v, 64'h0);
        check("R4 irq dropped", 64'(irq_o[0]), 64'd0);
        repeat (20) @(negedge clk_i);
        rd(5'd2, v);
        check("R7 fires once", v, 64'h0);

        // R6 disabled interrupt on channel 1
        rd(5'd3, v);
        wr(5'd6, 64'h1);
        wr(5'd7, v + 64'd10);
        repeat (12) @(negedge clk_i);
        rd(5'd2, w);
        check("R6 status still set", w, 64'h2);
        check("R6 no irq", 64'(irq_o[1]), 64'd0);
        wr(5'd2, 64'h2);

        // R3 write ignored while running, R2 hold
        rd(5'd3, v);
        wr(5'd3, 64'd5);
        rd(5'd3, w);
        check("R3 load ignored while running", w, v + 64'd1);
        wr(5'd1, 64'd0);
        rd(5'd3, v);
        repeat (3) @(negedge clk_i);
        rd(5'd3, w);
        check("R2 counter holds", w, v);

        // R8 / R9 / R12 periodic edge on channel 0
        wr(5'd3, 64'd0);
        wr(5'd4, 64'h16);
        wr(5'd5, 64'd20);
        rd(5'd4, v);
        check("R8 value-set self clears", v, 64'hE);
        wr(5'd5, 64'd7);
        rd(5'd5, v);
        check("R8 first match kept", v, 64'd20);
        wr(5'd1, 64'd1);
        repeat (20) @(negedge clk_i);
        check("R12 no pulse before match", 64'(irq_o[0]), 64'd0);
        @(negedge clk_i);
        check("R12 pulse on match", 64'(irq_o[0]), 64'd1);
        rd(5'd5, v);
        check("R9 comparator advanced", v, 64'd27);
        @(negedge clk_i);
        check("R12 pulse one cycle", 64'(irq_o[0]), 64'd0);
        repeat (6) @(negedge clk_i);
        check("R9 second periodic match", 64'(irq_o[0]), 64'd1);
        rd(5'd2, v);
        check("R12 edge sets no status", v, 64'h0);

        // R11 low-32 match on channel 1
        wr(5'd1, 64'd0);
        wr(5'd3, 64'h5_0000_0000);
        wr(5'd6, 64'h23);
        wr(5'd7, 64'h7_0000_0004);
        wr(5'd1, 64'd1);
        repeat (4) @(negedge clk_i);
        check("R11 no irq before low match", 64'(irq_o[1]), 64'd0);
        @(negedge clk_i);
        check("R11 low 32-bit match", 64'(irq_o[1]), 64'd1);

        // R5 match and clear in the same cycle
        wr(5'd1, 64'd0);
        wr(5'd3, 64'h10);
        wr(5'd7, 64'h14);
        wr(5'd1, 64'd1);
        repeat (4) @(negedge clk_i);
        wr(5'd2, 64'h2);
        rd(5'd2, v);
        check("R5 set wins over clear", v & 64'h2, 64'h2);
        check("R5 irq after collision", 64'(irq_o[1]), 64'd1);
        wr(5'd2, 64'h2);
        rd(5'd2, v);
        check("R4 clear after collision", v & 64'h2, 64'h0);

        finish_run();
    end
endmodule